// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of one burst access into a 256-column page of a synchronous graphics DRAM. A controller raises `start` with a start column and a copy of the programmed mode (burst length code, burst type, single-write option and whether the access is a write). From the next cycle on, the block shows the current column, a valid flag and a last-beat flag. It moves to the next column on every cycle in which `step_en` is high.

Fixed-length bursts of 2, 4 and 8 wrap within an aligned block of that size. The order is linear (count up) or interleaved (start XOR beat index). Full-page bursts count up through the whole row, wrap at column 255 and run until `stop` is raised. The mode is captured when `start` is accepted, so the mode inputs may change while a burst is in progress.

Top module: `burst_col_gen`

## Requirements
- R1: During and right after a synchronous active-low reset, `col_valid` and `last_beat` are 0 and `col` is 0.
- R2: In the cycle after `start` is sampled high, `col_valid` is 1 and `col` equals the sampled `start_col`, whatever `step_en` is. This also holds during an active burst, where it restarts the sequence.
- R3: The `burst_len` code selects the length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 give length 1. A fixed-length burst stays valid for exactly that many stepped beats and then drops `col_valid`.
- R4: With `interleave`=0 and a length BL of 2, 4 or 8, beat i shows the start column with its low log2(BL) bits replaced by (start+i) mod BL. The upper bits do not change.
- R5: With `interleave`=1 and a length BL of 2, 4 or 8, beat i shows start_col XOR i.
- R6: In full-page mode, beat i shows (start_col+i) mod 256 and `interleave` is ignored. The burst keeps running past 256 beats and never raises `last_beat`.
- R7: For fixed lengths, `last_beat` is 1 exactly while `col_valid` is 1 and the burst is on beat BL-1.
- R8: If `stop` is high while a burst is valid and `start` is low, `col_valid` is 0 in the next cycle. `start` takes priority over `stop`.
- R9: While a burst is valid and `step_en`, `stop` and `start` are all low, `col`, `col_valid` and `last_beat` keep their values.
- R10: If `is_write`=1 and `single_write`=1 when `start` is accepted, the burst has length 1. Reads keep the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin (or restart) a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| burst_len | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 1 = interleaved order, 0 = linear |
| single_write | input | 1 | 1 = write bursts forced to one beat |
| is_write | input | 1 | Access being started is a write |
| step_en | input | 1 | Advance to the next beat |
| stop | input | 1 | Terminate the current burst |
| col | output | 8 | Current column address |
| col_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench goes after the wrap points. A linear burst that starts in the middle of an aligned block must fold back to the bottom of that block and leave the upper bits alone; a design that carries into the upper bits would walk into the next block. A full-page burst runs for more than 256 beats. A design that stops at 255, or that raises `last_beat` there, would end a transfer that only `stop` may end. Restarts in the middle of a burst and collisions between `stop` and `start` check the priority order. A write under the single-write option that kept the programmed length would show more than one beat. Reserved length codes must give one beat.

// File: rtl/burst_pkg.sv
// Package: shared constants and length-code decoding for the burst column
// generator. Assumes an 8-bit column by default (256-column page).
package burst_pkg;
    localparam int unsigned COL_W = 8;

    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } bl_code_e;

    // Return the wrap mask for a length code (all ones means full page).
    function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        case (code)
            BL_TWO:   m = COL_W'(1);
            BL_FOUR:  m = COL_W'(3);
            BL_EIGHT: m = COL_W'(7);
            BL_PAGE:  m = '1;
            default:  m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/burst_cfg_dec.sv
// Module: burst_cfg_dec
// Turns the mode inputs into an effective wrap mask, a full-page flag and an
// order flag. It applies the single-write override for write accesses and maps
// reserved length codes to one beat. Purely combinational.
module burst_cfg_dec
    import burst_pkg::*;
#(
    parameter int unsigned CW = COL_W
) (
    input  logic [2:0]    len_code,
    input  logic          interleave,
    input  logic          single_write,
    input  logic          is_write,
    output logic [CW-1:0] mask,
    output logic          full_page,
    output logic          il_order
);
    logic [2:0] eff_code;

    // Pick the length code that really applies to this access.
    always_comb begin
        eff_code  = (is_write && single_write) ? BL_ONE : len_code;
        mask      = CW'(len_mask(eff_code));
        full_page = (eff_code == BL_PAGE);
        il_order  = interleave && (eff_code != BL_PAGE);
    end
endmodule

// File: rtl/burst_seq_ctrl.sv
// Module: burst_seq_ctrl
// Holds the burst state: active flag, captured start column, beat counter and
// the captured configuration. Priority is reset, start, stop, step. Assumes the
// configuration inputs are already decoded by burst_cfg_dec.
module burst_seq_ctrl #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_col,
    input  logic          step_en,
    input  logic          stop,
    input  logic [CW-1:0] mask_in,
    input  logic          full_in,
    input  logic          il_in,
    output logic          active,
    output logic [CW-1:0] base,
    output logic [CW-1:0] beat,
    output logic [CW-1:0] mask_q,
    output logic          full_q,
    output logic          il_q,
    output logic          last
);
    // Final beat of a fixed-length burst.
    always_comb last = active && !full_q && (beat == mask_q);

    // Sequence state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            beat   <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            il_q   <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            base   <= start_col;
            beat   <= '0;
            mask_q <= mask_in;
            full_q <= full_in;
            il_q   <= il_in;
        end else if (active && stop) begin
            active <= 1'b0;
        end else if (active && step_en) begin
            if (last) active <= 1'b0;
            else      beat   <= beat + 1'b1;
        end
    end

    // R7/R3: stepping past the final beat ends the burst.
    assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last && step_en && !stop && !start) |=> !active);

    // R8: stop ends a valid burst on the next cycle.
    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && stop && !start) |=> !active);

    // R9: no step, no stop, no start keeps the beat and state.
    assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !step_en && !stop && !start) |=> (active && $stable(beat)));

    // R6: a full-page burst never reports a final beat.
    assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && full_q) |-> !last);
endmodule

// File: rtl/burst_addr_map.sv
// Module: burst_addr_map
// Maps the start column and beat index to the column for that beat. Bits under
// the mask advance linearly or by XOR, and bits above it stay fixed. A full
// mask gives plain modulo-2^CW counting. Combinational.
module burst_addr_map #(
    parameter int unsigned CW = 8
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] beat,
    input  logic [CW-1:0] mask,
    input  logic          il_order,
    output logic [CW-1:0] col
);
    logic [CW-1:0] lin_sum;

    // Select interleaved or linear wrapped address.
    always_comb begin
        lin_sum = base + beat;
        if (il_order) col = base ^ (beat & mask);
        else          col = (base & ~mask) | (lin_sum & mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Column address generator for one burst within a DRAM page. It decodes the
// mode, keeps the sequence state and maps beats to columns. Outputs are
// registered-state driven and change the cycle after the controlling edge.
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int unsigned CW = COL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_col,
    input  logic [2:0]    burst_len,
    input  logic          interleave,
    input  logic          single_write,
    input  logic          is_write,
    input  logic          step_en,
    input  logic          stop,
    output logic [CW-1:0] col,
    output logic          col_valid,
    output logic          last_beat
);
    logic [CW-1:0] dec_mask, base, beat, mask_q;
    logic          dec_full, dec_il, full_q, il_q;

    burst_cfg_dec #(.CW(CW)) cfg_i (
        .len_code(burst_len), .interleave(interleave),
        .single_write(single_write), .is_write(is_write),
        .mask(dec_mask), .full_page(dec_full), .il_order(dec_il)
    );

    burst_seq_ctrl #(.CW(CW)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .step_en(step_en), .stop(stop),
        .mask_in(dec_mask), .full_in(dec_full), .il_in(dec_il),
        .active(col_valid), .base(base), .beat(beat),
        .mask_q(mask_q), .full_q(full_q), .il_q(il_q), .last(last_beat)
    );

    burst_addr_map #(.CW(CW)) map_i (
        .base(base), .beat(beat), .mask(mask_q), .il_order(il_q), .col(col)
    );

    // R2: an accepted start shows its column on the next cycle.
    assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col == $past(start_col)));

    // R4/R5: bits above the wrap block never change while stepping.
    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && step_en && !stop && !start && !last_beat)
        |=> (((col ^ $past(col)) & ~$past(mask_q)) == '0));
endmodule

// File: tb/burst_col_gen_tb_top.sv
// Bench: random and directed stimulus checked against a reference model
// built from the requirements.
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, interleave = 1'b0, single_write = 1'b0;
    logic       is_write = 1'b0, step_en = 1'b0, stop = 1'b0;
    logic [7:0] start_col = 8'h0;
    logic [2:0] burst_len = 3'd0;
    logic [7:0] col;
    logic       col_valid, last_beat;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    bit m_act = 0, m_full = 0, m_il = 0;
    int m_base = 0, m_beat = 0, m_bl = 1;

    always #4 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .burst_len(burst_len), .interleave(interleave),
        .single_write(single_write), .is_write(is_write),
        .step_en(step_en), .stop(stop),
        .col(col), .col_valid(col_valid), .last_beat(last_beat)
    );

    function automatic int len_of(input logic [2:0] c, input bit wr, input bit sw);
        if (wr && sw) return 1;
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col();
        int msk;
        if (m_full) return (m_base + m_beat) % 256;
        msk = m_bl - 1;
        if (m_il) return m_base ^ m_beat;
        return (m_base & ~msk & 255) | ((m_base + m_beat) & msk);
    endfunction

    function automatic bit exp_last();
        return m_act && !m_full && (m_beat == m_bl - 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one clock using the current inputs.
    task automatic model_step();
        if (!rst_n) begin
            m_act = 0; m_base = 0; m_beat = 0; m_bl = 1; m_full = 0; m_il = 0;
        end else if (start) begin
            m_act = 1; m_base = start_col; m_beat = 0;
            m_bl = len_of(burst_len, is_write, single_write);
            m_full = (m_bl == 0);
            m_il = interleave && !m_full;
        end else if (m_act && stop) begin
            m_act = 0;
        end else if (m_act && step_en) begin
            if (exp_last()) m_act = 0;
            else m_beat = (m_beat + 1) % 256;
        end
    endtask

    // One cycle: inputs already set at negedge; clock, update model, compare.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " valid R3"}, col_valid, m_act);
        check({tag, " last R7"}, last_beat, exp_last());
        if (m_act)
            check(m_full ? {tag, " col R6"} : (m_il ? {tag, " col R5"} : {tag, " col R4"}),
                  col, exp_col());
    endtask

    task automatic set_in(input bit st, input int sc, input int bl, input bit il,
                          input bit sw, input bit wr, input bit se, input bit sp);
        start = st; start_col = 8'(sc); burst_len = 3'(bl); interleave = il;
        single_write = sw; is_write = wr; step_en = se; stop = sp;
    endtask

    task automatic run_steps(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            set_in(0, 0, 0, 0, 0, 0, 1, 0);
            cycle(tag);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        rst_n = 0;
        cycle("reset");
        cycle("reset");
        check("reset col R1", col, 0);
        check("reset valid R1", col_valid, 0);
        check("reset last R1", last_beat, 0);
        rst_n = 1;

        // R4: linear 8 from mid-block, wraps inside block of 8.
        set_in(1, 8'h2D, 3, 0, 0, 0, 0, 0); cycle("lin8 start R2");
        run_steps(9, "lin8");
        // R5: interleaved 4.
        set_in(1, 8'h92, 2, 1, 0, 0, 1, 0); cycle("il4 start R2");
        run_steps(5, "il4");
        // R9: hold while step_en low.
        set_in(1, 8'h41, 2, 0, 0, 0, 0, 0); cycle("hold start R2");
        for (int i = 0; i < 3; i++) begin
            set_in(0, 0, 0, 0, 0, 0, 0, 0); cycle("hold R9");
            check("hold col R9", col, 8'h41);
        end
        run_steps(4, "hold");
        // R6: full page across wrap, interleave ignored, then stop.
        set_in(1, 8'hF0, 7, 1, 0, 0, 1, 0); cycle("page start R2");
        run_steps(300, "page");
        set_in(0, 0, 0, 0, 0, 0, 1, 1); cycle("page stop R8");
        check("page stopped R8", col_valid, 0);
        // R10: single write forces one beat; read keeps length.
        set_in(1, 8'h10, 3, 0, 1, 1, 1, 0); cycle("sw write R10");
        check("sw last R10", last_beat, 1);
        run_steps(1, "sw write R10");
        check("sw ended R10", col_valid, 0);
        set_in(1, 8'h10, 3, 0, 1, 0, 1, 0); cycle("sw read R10");
        run_steps(8, "sw read R10");
        // R3: reserved code gives one beat.
        set_in(1, 8'h77, 5, 0, 0, 0, 1, 0); cycle("reserved R3");
        check("reserved last R3", last_beat, 1);
        run_steps(2, "reserved R3");
        // R2/R8: restart mid-burst; start beats stop.
        set_in(1, 8'h30, 3, 0, 0, 0, 1, 0); cycle("restart a R2");
        run_steps(2, "restart");
        set_in(1, 8'hC5, 2, 1, 0, 0, 1, 1); cycle("restart b R2 R8");
        check("restart col R2", col, 8'hC5);
        run_steps(4, "restart");

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            int codes[6] = '{0, 1, 2, 3, 5, 7};
            set_in(($urandom % 10) == 0, $urandom % 256, codes[$urandom % 6],
                   $urandom % 2, $urandom % 2, $urandom % 2,
                   ($urandom % 4) != 0, ($urandom % 25) == 0);
            cycle("rand");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule